// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block looks after even parity on a 32-bit multiplexed address/data bus that travels with a 4-bit command/byte-enable bus. When the local agent drives the bus, the block produces the parity bit one clock later, together with that bit's output enable. When another agent drives data that this agent takes part in, the block recomputes parity on the edge where the data phase completes. It then compares the result against the parity bit that arrives on the following clock.

On a data mismatch the block pulls the active-low parity error line low two clocks after the data, provided that parity error response is enabled. After an assertion it drives the line high for one clock before it releases the line's output enable. During an address phase it also checks address parity for I/O, memory and configuration commands. Both kinds of parity event reach the status logic as single-cycle pulses. The block does not signal system errors.

Top module: `bpar_unit`

## Requirements
- R1: Whenever `par_oe_o` is high, the number of ones across `par_o` and the `ad_i`/`cbe_i` values of the previous cycle is even.
- R2: `par_oe_o` is high in the cycle after each cycle with `ad_oe_i` high, and low in the cycle after each cycle with `ad_oe_i` low.
- R3: Suppose that in cycle N `xfer_i`=1, `claim_i`=1 and `ad_oe_i`=0. If `par_i` in cycle N+1 does not give even parity with the cycle-N `ad_i`/`cbe_i`, and `per_en_i`=1 in cycle N+1, then `perr_n_o`=0 and `perr_oe_o`=1 in cycle N+2.
- R4: Each faulty data phase produces exactly one low cycle of `perr_n_o`. Back-to-back faulty phases give back-to-back low cycles, and a clean phase gives a high cycle.
- R5: A data phase with `claim_i`=0, or with `ad_oe_i`=1, or a cycle with `xfer_i`=0, never causes `perr_n_o` to go low or `evt_dpe_o` to pulse.
- R6: After the last low cycle of `perr_n_o`, the output is driven high with `perr_oe_o`=1 for exactly one cycle, and `perr_oe_o` is 0 in the cycle after that.
- R7: A data parity error pulses `evt_dpe_o` in cycle N+2 whatever the value of `per_en_i`. With `per_en_i`=0, `perr_oe_o` stays 0.
- R8: `evt_dpd_o` pulses in cycle N+2 only when `perr_n_o` is asserted for that data phase.
- R9: Suppose `addr_vld_i`=1 in cycle A, the command on `cbe_i` is one of 0010, 0011, 0110, 0111, 1010, 1011, 1100, 1110 or 1111, and `par_i` in A+1 gives odd parity. Then `evt_dpe_o` pulses in A+2 without `evt_dpd_o` and without PERR. Any other command, for example 0001, is not checked.
- R10: While `rst_n` is low, and in the first cycle after reset, `par_oe_o`=0, `perr_oe_o`=0, `perr_n_o`=1 and both event pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 32 | Address/data value on the bus this cycle |
| cbe_i | input | 4 | Command or byte enables on the bus this cycle |
| ad_oe_i | input | 1 | Local agent drives ad/cbe this cycle |
| addr_vld_i | input | 1 | This cycle is an address phase |
| claim_i | input | 1 | Local agent takes part in the current data phase |
| xfer_i | input | 1 | A data phase completes on this edge |
| par_i | input | 1 | Parity bit observed on the bus |
| per_en_i | input | 1 | Parity error response enable |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for par_o |
| perr_n_o | output | 1 | Active-low data parity error |
| perr_oe_o | output | 1 | Output enable for perr_n_o |
| evt_dpd_o | output | 1 | Pulse: data parity error reported on the bus |
| evt_dpe_o | output | 1 | Pulse: parity error detected (data or address) |

## Verification
The hardest situation to reach is a run of consecutive completed data phases whose parity is bad, then good, then followed by idle. Only that pattern shows whether the two-clock error pipeline keeps one phase apart from the next and whether the one-clock high tail comes after the last assertion rather than after each one. The burst scenario keeps `xfer_i` high over three cycles and shifts the deliberately wrong `par_i` by one cycle behind each data word. It then watches `perr_n_o` and `perr_oe_o` in each of the following cycles until the output enable drops.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  localparam int AD_W_DEF = 32;
  localparam int BE_W_DEF = 4;
  localparam int CMD_W    = 4;

  // Commands whose address phase parity is checked: I/O, memory, configuration.
  function automatic logic cmd_checked(input logic [CMD_W-1:0] cmd);
    logic hit;
    case (cmd)
      4'b0010, 4'b0011,                   // I/O read / write
      4'b0110, 4'b0111,                   // memory read / write
      4'b1010, 4'b1011,                   // configuration read / write
      4'b1100, 4'b1110, 4'b1111: hit = 1'b1; // memory multi / line / invalidate
      default:                   hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/bpar_gen.sv
module bpar_gen #(
  parameter int AD_W = bpar_pkg::AD_W_DEF,
  parameter int BE_W = bpar_pkg::BE_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic            ad_oe_i,
  output logic            par_o,
  output logic            par_oe_o
);
  localparam int W = AD_W + BE_W;

  function automatic logic even_fill(input logic [W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < W; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  logic par_next;
  assign par_next = even_fill({ad_i, cbe_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= par_next;
      par_oe_o <= ad_oe_i;
    end
  end

  a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_i |=> ((^{par_o, $past(ad_i), $past(cbe_i)}) == 1'b0));
  a_r2_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_i |=> par_oe_o);
  a_r2_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe_i |=> !par_oe_o);
endmodule

// File: rtl/bpar_dchk.sv
module bpar_dchk #(
  parameter int AD_W = bpar_pkg::AD_W_DEF,
  parameter int BE_W = bpar_pkg::BE_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic            ad_oe_i,
  input  logic            claim_i,
  input  logic            xfer_i,
  input  logic            par_i,
  output logic            data_err_o
);
  localparam int W = AD_W + BE_W;

  function automatic logic even_fill(input logic [W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < W; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  logic cap_vld, cap_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld <= 1'b0;
      cap_par <= 1'b0;
    end else begin
      cap_vld <= xfer_i & claim_i & ~ad_oe_i;
      cap_par <= even_fill({ad_i, cbe_i});
    end
  end

  assign data_err_o = cap_vld & (cap_par != par_i);

  a_r5_err_needs_rx_phase: assert property (@(posedge clk) disable iff (!rst_n)
    data_err_o |-> $past(xfer_i && claim_i && !ad_oe_i));
endmodule

// File: rtl/bpar_achk.sv
module bpar_achk #(
  parameter int AD_W = bpar_pkg::AD_W_DEF,
  parameter int BE_W = bpar_pkg::BE_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic            addr_vld_i,
  input  logic            par_i,
  output logic            addr_err_o
);
  localparam int W = AD_W + BE_W;

  function automatic logic even_fill(input logic [W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < W; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  logic acap_vld, acap_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acap_vld <= 1'b0;
      acap_par <= 1'b0;
    end else begin
      acap_vld <= addr_vld_i & bpar_pkg::cmd_checked(cbe_i[bpar_pkg::CMD_W-1:0]);
      acap_par <= even_fill({ad_i, cbe_i});
    end
  end

  assign addr_err_o = acap_vld & (acap_par != par_i);

  a_r9_addr_needs_phase: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |-> $past(addr_vld_i));
endmodule

// File: rtl/bpar_perr_drv.sv
module bpar_perr_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic data_err_i,
  input  logic addr_err_i,
  input  logic per_en_i,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic dpd_o,
  output logic dpe_o
);
  logic perr_q, tail_q, dpe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      tail_q <= 1'b0;
      dpe_q  <= 1'b0;
    end else begin
      perr_q <= data_err_i & per_en_i;
      tail_q <= perr_q;
      dpe_q  <= data_err_i | addr_err_i;
    end
  end

  assign perr_n_o  = ~perr_q;
  assign perr_oe_o = perr_q | tail_q;
  assign dpd_o     = perr_q;
  assign dpe_o     = dpe_q;

  a_r3_perr_two_after: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err_i && per_en_i) |=> (!perr_n_o && perr_oe_o));
  a_r6_high_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe_o && !perr_n_o) |=> perr_oe_o);
  a_r7_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err_i && !per_en_i && !perr_oe_o) |=> (dpe_o && !dpd_o && perr_n_o));
  a_r8_dpd_implies_dpe: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_o |-> dpe_o);
endmodule

// File: rtl/bpar_unit.sv
module bpar_unit #(
  parameter int AD_W = bpar_pkg::AD_W_DEF,
  parameter int BE_W = bpar_pkg::BE_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic            ad_oe_i,
  input  logic            addr_vld_i,
  input  logic            claim_i,
  input  logic            xfer_i,
  input  logic            par_i,
  input  logic            per_en_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            perr_n_o,
  output logic            perr_oe_o,
  output logic            evt_dpd_o,
  output logic            evt_dpe_o
);
  logic data_err;
  logic addr_err;

  bpar_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .ad_oe_i(ad_oe_i), .par_o(par_o), .par_oe_o(par_oe_o)
  );

  bpar_dchk #(.AD_W(AD_W), .BE_W(BE_W)) u_dchk (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .ad_oe_i(ad_oe_i), .claim_i(claim_i), .xfer_i(xfer_i),
    .par_i(par_i), .data_err_o(data_err)
  );

  bpar_achk #(.AD_W(AD_W), .BE_W(BE_W)) u_achk (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .addr_vld_i(addr_vld_i), .par_i(par_i), .addr_err_o(addr_err)
  );

  bpar_perr_drv u_drv (
    .clk(clk), .rst_n(rst_n), .data_err_i(data_err), .addr_err_i(addr_err),
    .per_en_i(per_en_i), .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
    .dpd_o(evt_dpd_o), .dpe_o(evt_dpe_o)
  );

  a_r5_perr_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(claim_i && xfer_i && !ad_oe_i, 2));
  a_r9_addr_no_perr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err && !data_err) |=> (evt_dpe_o && !evt_dpd_o && perr_n_o));
endmodule

// File: tb/bpar_unit_tb.sv
module bpar_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        ad_oe_i = 1'b0, addr_vld_i = 1'b0, claim_i = 1'b0;
  logic        xfer_i = 1'b0, par_i = 1'b0, per_en_i = 1'b1;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o, evt_dpd_o, evt_dpe_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bpar_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .ad_oe_i(ad_oe_i),
    .addr_vld_i(addr_vld_i), .claim_i(claim_i), .xfer_i(xfer_i), .par_i(par_i),
    .per_en_i(per_en_i), .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o),
    .perr_oe_o(perr_oe_o), .evt_dpd_o(evt_dpd_o), .evt_dpe_o(evt_dpe_o)
  );

  // Fill bit that makes the 36-bit group even, by counting.
  function automatic logic fill_bit(input logic [31:0] a, input logic [3:0] c);
    int n;
    n = $countones(a) + $countones(c);
    return (n % 2) == 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    ad_oe_i = 0; addr_vld_i = 0; claim_i = 0; xfer_i = 0; par_i = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    tick(); tick();
    chk("R10", "par_oe", par_oe_o, 0);
    chk("R10", "perr_oe", perr_oe_o, 0);
    chk("R10", "perr_n", perr_n_o, 1);
    chk("R10", "events", {evt_dpd_o, evt_dpe_o}, 0);
    rst_n = 1;
    tick();
    chk("R10", "perr_n after reset", perr_n_o, 1);
    chk("R10", "par_oe after reset", par_oe_o, 0);
  endtask

  task automatic t_gen();
    logic [31:0] pa [5] = '{32'h0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8421_1248, 32'hDEAD_BEEF};
    logic [3:0]  pc [5] = '{4'h0, 4'hF, 4'h0, 4'h7, 4'hA};
    for (int k = 0; k < 5; k++) begin
      ad_oe_i = 1; ad_i = pa[k]; cbe_i = pc[k];
      tick();
      chk("R2", "par_oe while driving", par_oe_o, 1);
      chk("R1", "par value", par_o, fill_bit(pa[k], pc[k]));
    end
    ad_oe_i = 0;
    tick();
    chk("R2", "par_oe after drive stops", par_oe_o, 0);
  endtask

  task automatic t_data_err();
    ad_i = 32'h1234_5678; cbe_i = 4'h3; claim_i = 1; xfer_i = 1; ad_oe_i = 0;
    tick();
    xfer_i = 0; claim_i = 0; per_en_i = 1; par_i = ~fill_bit(32'h1234_5678, 4'h3);
    chk("R3", "perr_n one clock after data", perr_n_o, 1);
    tick();
    par_i = 0;
    chk("R3", "perr_n two clocks after data", perr_n_o, 0);
    chk("R3", "perr_oe", perr_oe_o, 1);
    chk("R7", "dpe pulse", evt_dpe_o, 1);
    chk("R8", "dpd pulse", evt_dpd_o, 1);
    tick();
    chk("R6", "tail perr_n high", perr_n_o, 1);
    chk("R6", "tail perr_oe", perr_oe_o, 1);
    chk("R7", "dpe single", evt_dpe_o, 0);
    tick();
    chk("R6", "perr_oe released", perr_oe_o, 0);
  endtask

  task automatic t_burst();
    // d0 bad, d1 bad, d2 good
    claim_i = 1; xfer_i = 1; ad_i = 32'hA5A5_0001; cbe_i = 4'h0;
    tick();
    par_i = ~fill_bit(32'hA5A5_0001, 4'h0);
    ad_i = 32'h0F0F_0002; cbe_i = 4'h1;
    tick();
    chk("R4", "d0 low", perr_n_o, 0);
    par_i = ~fill_bit(32'h0F0F_0002, 4'h1);
    ad_i = 32'h7777_0003; cbe_i = 4'h2;
    tick();
    chk("R4", "d1 low", perr_n_o, 0);
    chk("R6", "no release between", perr_oe_o, 1);
    xfer_i = 0; claim_i = 0;
    par_i = fill_bit(32'h7777_0003, 4'h2);
    tick();
    chk("R4", "d2 clean high", perr_n_o, 1);
    chk("R6", "tail after burst", perr_oe_o, 1);
    chk("R4", "no dpe for clean", evt_dpe_o, 0);
    par_i = 0;
    tick();
    chk("R6", "released after burst", perr_oe_o, 0);
  endtask

  task automatic t_ignore(input int mode);
    // mode 0: not claimed, 1: own drive, 2: no completion
    ad_i = 32'h0000_00FF; cbe_i = 4'h5;
    claim_i = (mode != 0); ad_oe_i = (mode == 1); xfer_i = (mode != 2);
    tick();
    idle(); par_i = ~fill_bit(32'h0000_00FF, 4'h5);
    tick();
    par_i = 0;
    chk("R5", "perr_n stays high", perr_n_o, 1);
    chk("R5", "no dpe", evt_dpe_o, 0);
    chk("R5", "perr_oe stays low", perr_oe_o, 0);
    tick();
  endtask

  task automatic t_noresp();
    ad_i = 32'h3C3C_3C3C; cbe_i = 4'h9; claim_i = 1; xfer_i = 1;
    tick();
    idle(); per_en_i = 0; par_i = ~fill_bit(32'h3C3C_3C3C, 4'h9);
    tick();
    par_i = 0; per_en_i = 1;
    chk("R7", "dpe with response off", evt_dpe_o, 1);
    chk("R7", "perr_oe off", perr_oe_o, 0);
    chk("R8", "no dpd", evt_dpd_o, 0);
    tick();
  endtask

  task automatic t_addr(input logic [3:0] cmd, input bit bad, input int exp_dpe);
    ad_i = 32'h8000_1000; cbe_i = cmd; addr_vld_i = 1;
    tick();
    idle(); par_i = bad ? ~fill_bit(32'h8000_1000, cmd) : fill_bit(32'h8000_1000, cmd);
    tick();
    par_i = 0;
    chk("R9", "address dpe", evt_dpe_o, exp_dpe);
    chk("R9", "no dpd on address", evt_dpd_o, 0);
    chk("R9", "no perr on address", perr_oe_o, 0);
    tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gen();
    t_data_err();
    t_burst();
    t_ignore(0);
    t_ignore(1);
    t_ignore(2);
    t_noresp();
    t_addr(4'b0110, 1, 1);
    t_addr(4'b1011, 1, 1);
    t_addr(4'b0001, 1, 0);
    t_addr(4'b0111, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule